// File: doc/BRIEF.md
# Hierarchical Multi-Channel DMA Engine

This block copies data from source addresses to destination addresses with no processor involvement. Each channel works through a transaction. A transaction is a programmed number of transfers, and each transfer is a run of 1 to 16 moves. A move is a read of one data item from the source followed by a write of that item to the destination. A pulse on a channel's hardware request line, such as a peripheral's conversion-done event, asks for one transfer on that channel.

Software sets up each channel through a small write-only register port. It programs a source pointer, a destination pointer, a transfer count and a control word. The control word holds the moves per transfer, the move size, address-hold flags, circular windows and the interrupt enable.

One shared move engine drives a memory master. The master has a read-request phase, a read-response phase and a write phase, each with valid/ready handshaking. Arbitration takes place only between transfers. The pending channel with the highest index wins, so a long transaction can be overtaken between two of its transfers. A transfer that has started always runs to its last move. A channel that is overtaken keeps its remaining count and current pointers, and later continues from that point.

Top module: `dma_hier_engine`

## Requirements
- R1: A transfer performs exactly (control bits [3:0] + 1) moves. Each move is one read-request handshake, then one read response, then one write handshake. A write never starts before the response of the same move has arrived.
- R2: The write data of a move equals the read response data of that move. The low 8·2^size bits are significant.
- R3: The move size code in control bits [6:4] selects 2^code bytes for codes 0 to 5. Codes 6 and 7 act as 5. The code is shown on rd_size and wr_size, and a pointer that is not held advances by 2^code after each move.
- R4: Control bit 7 holds the source pointer and control bit 8 holds the destination pointer. A held pointer keeps the same value across all moves and transfers.
- R5: A non-zero circular field k (source in control bits [12:9], destination in [16:13]) confines the low k pointer bits. The pointer wraps inside its aligned 2^k-byte window.
- R6: Register select 2 loads the transfer count, select 0 the source pointer, select 1 the destination pointer and select 3 the control word. Each finished transfer lowers the count by one. A request to a channel whose count is zero is ignored and causes no bus activity.
- R7: When the engine is idle, the eligible channel with the highest index is granted. A channel is eligible when it has a latched request and a non-zero count.
- R8: A higher-index request can overtake a transaction only between its transfers. The overtaken channel later resumes with its stored count and pointers.
- R9: A request that arrives while its own channel's transfer is in progress is latched and served later.
- R10: When the last transfer of a transaction completes and control bit 17 is set, irq[ch] pulses for one cycle. Otherwise the channel raises no interrupt, and at most one irq bit is high in any cycle.
- R11: After reset, rd_valid, wr_valid and irq are low.
- R12: While rd_valid or wr_valid waits for ready, it stays high with its address (and, for writes, its data) unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CHW | Channel being written |
| cfg_sel | input | 2 | Register select (0 src, 1 dst, 2 count, 3 control) |
| cfg_wdata | input | 32 | Register write data |
| hw_req | input | NCH | Per-channel transfer request pulses |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | AW | Read address |
| rd_size | output | 3 | Read size code |
| rd_ready | input | 1 | Read request accepted |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | DW | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | AW | Write address |
| wr_size | output | 3 | Write size code |
| wr_data | output | DW | Write data |
| wr_ready | input | 1 | Write accepted |
| irq | output | NCH | Transaction-complete pulses |

## Verification
The first pattern is a single channel with a multi-transfer transaction and incrementing pointers. It checks move counting, count decrement and the timing of the interrupt. Held pointers, the largest move size and a circular source window each get their own run, which separates the three address-update paths. Three channels requested in the same cycle show the grant order. The bench then issues a mid-transfer request from both the running channel and a higher-index channel, which separates the atomic transfer from the pre-emption between transfers and also shows that the resumed pointers are correct. A final request to an exhausted channel must leave the bus quiet.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef struct packed {
    logic       irq_en;
    logic [3:0] dst_circ;
    logic [3:0] src_circ;
    logic       dst_hold;
    logic       src_hold;
    logic [2:0] size;
    logic [3:0] moves_m1;
  } chan_cfg_t;

  localparam int CFG_BITS = $bits(chan_cfg_t);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_RWAIT, ST_WR, ST_DONE
  } eng_state_t;

  function automatic logic [2:0] eff_size(input logic [2:0] code);
    return (code > 3'd5) ? 3'd5 : code;
  endfunction

  function automatic chan_cfg_t unpack_ctrl(input logic [31:0] w);
    return chan_cfg_t'(w[CFG_BITS-1:0]);
  endfunction

  // Pointer update after one move: hold, plain increment, or wrap in window.
  function automatic logic [63:0] step_addr(input logic [63:0] a,
                                            input logic [2:0]  code,
                                            input logic        hold,
                                            input logic [3:0]  circ);
    logic [63:0] inc, sum, mask;
    inc  = 64'd1 << eff_size(code);
    sum  = a + inc;
    mask = (64'd1 << circ) - 64'd1;
    if (hold)           return a;
    else if (circ == 0) return sum;
    else                return (a & ~mask) | (sum & mask);
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [31:0]      wr_data,
  input  logic             hw_req,
  input  logic             xfer_start,
  input  logic             wb_en,
  input  logic [AW-1:0]    wb_src,
  input  logic [AW-1:0]    wb_dst,
  output logic [AW-1:0]    src_addr,
  output logic [AW-1:0]    dst_addr,
  output chan_cfg_t        cfg,
  output logic             eligible,
  output logic             irq_pulse
);

  logic [CNT_W-1:0] remaining;
  logic             pend_q;
  logic             last_xfer;

  assign last_xfer = (remaining == CNT_W'(1));
  assign eligible  = pend_q && (remaining != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr  <= '0;
      dst_addr  <= '0;
      remaining <= '0;
      cfg       <= '0;
      pend_q    <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= 1'b0;
      if (wb_en) begin
        src_addr  <= wb_src;
        dst_addr  <= wb_dst;
        remaining <= remaining - CNT_W'(1);
        if (last_xfer && cfg.irq_en) irq_pulse <= 1'b1;
      end else if (wr_en) begin
        case (wr_sel)
          2'd0:    src_addr  <= wr_data[AW-1:0];
          2'd1:    dst_addr  <= wr_data[AW-1:0];
          2'd2:    remaining <= wr_data[CNT_W-1:0];
          default: cfg       <= unpack_ctrl(wr_data);
        endcase
      end
      // request bookkeeping: grant consumes, new request latches, exhaustion clears
      if (xfer_start)                   pend_q <= 1'b0;
      if (hw_req && remaining != '0)    pend_q <= 1'b1;
      if (wb_en && last_xfer)           pend_q <= 1'b0;
    end
  end

  AST_WB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> remaining != '0);                                           // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> remaining == $past(remaining) - CNT_W'(1));                 // R6
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (remaining == '0) && $past(wb_en));                     // R10

endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
  parameter int NCH = 8,
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] elig,
  output logic           gnt_valid,
  output logic [CHW-1:0] gnt_idx
);

  always_comb begin
    gnt_valid = |elig;
    gnt_idx   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (elig[i]) gnt_idx = CHW'(i);
    end
  end

  AST_GNT_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> elig[gnt_idx] && ((elig >> gnt_idx) == NCH'(1)));      // R7

endmodule

// File: rtl/dma_move_engine.sv
module dma_move_engine
  import dma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CHW = 3,
  parameter int AW  = 32,
  parameter int DW  = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           gnt_valid,
  input  logic [CHW-1:0] gnt_idx,
  input  logic [AW-1:0]  sel_src,
  input  logic [AW-1:0]  sel_dst,
  input  chan_cfg_t      sel_cfg,
  output logic           rd_valid,
  output logic [AW-1:0]  rd_addr,
  output logic [2:0]     rd_size,
  input  logic           rd_ready,
  input  logic           rd_rsp_valid,
  input  logic [DW-1:0]  rd_rsp_data,
  output logic           wr_valid,
  output logic [AW-1:0]  wr_addr,
  output logic [2:0]     wr_size,
  output logic [DW-1:0]  wr_data,
  input  logic           wr_ready,
  output logic           xfer_start,
  output logic           xfer_done,
  output logic           move_done,
  output logic [CHW-1:0] cur_ch,
  output logic [AW-1:0]  cur_src,
  output logic [AW-1:0]  cur_dst
);

  eng_state_t      state;
  chan_cfg_t       cfg_q;
  logic [3:0]      moves_left;
  logic [DW-1:0]   data_q;
  logic [AW-1:0]   src_nxt, dst_nxt;

  assign xfer_start = (state == ST_IDLE) && gnt_valid;
  assign xfer_done  = (state == ST_DONE);
  assign move_done  = (state == ST_WR) && wr_ready;
  assign rd_valid   = (state == ST_RD);
  assign wr_valid   = (state == ST_WR);
  assign rd_addr    = cur_src;
  assign wr_addr    = cur_dst;
  assign rd_size    = eff_size(cfg_q.size);
  assign wr_size    = eff_size(cfg_q.size);
  assign wr_data    = data_q;

  assign src_nxt = AW'(step_addr(64'(cur_src), cfg_q.size, cfg_q.src_hold, cfg_q.src_circ));
  assign dst_nxt = AW'(step_addr(64'(cur_dst), cfg_q.size, cfg_q.dst_hold, cfg_q.dst_circ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cfg_q      <= '0;
      moves_left <= '0;
      data_q     <= '0;
      cur_ch     <= '0;
      cur_src    <= '0;
      cur_dst    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (gnt_valid) begin
          cur_ch     <= gnt_idx;
          cur_src    <= sel_src;
          cur_dst    <= sel_dst;
          cfg_q      <= sel_cfg;
          moves_left <= sel_cfg.moves_m1;
          state      <= ST_RD;
        end
        ST_RD:    if (rd_ready) state <= ST_RWAIT;
        ST_RWAIT: if (rd_rsp_valid) begin
          data_q <= rd_rsp_data;
          state  <= ST_WR;
        end
        ST_WR: if (wr_ready) begin
          cur_src <= src_nxt;
          cur_dst <= dst_nxt;
          if (moves_left == 4'd0) begin
            state <= ST_DONE;
          end else begin
            moves_left <= moves_left - 4'd1;
            state      <= ST_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // checker-side move counter, independent of moves_left
  logic [4:0] chk_moves;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          chk_moves <= '0;
    else if (xfer_start) chk_moves <= '0;
    else if (move_done)  chk_moves <= chk_moves + 5'd1;
  end

  AST_MOVES_PER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> chk_moves == {1'b0, cfg_q.moves_m1} + 5'd1);            // R1
  AST_WR_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(rd_rsp_valid));                             // R1
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));              // R12
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R12
  AST_WR_DATA_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> wr_data == $past(rd_rsp_data));                   // R2

endmodule

// File: rtl/dma_hier_engine.sv
module dma_hier_engine
  import dma_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int AW    = 32,
  parameter int DW    = 256,
  parameter int CNT_W = 16,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [31:0]    cfg_wdata,
  input  logic [NCH-1:0] hw_req,
  output logic           rd_valid,
  output logic [AW-1:0]  rd_addr,
  output logic [2:0]     rd_size,
  input  logic           rd_ready,
  input  logic           rd_rsp_valid,
  input  logic [DW-1:0]  rd_rsp_data,
  output logic           wr_valid,
  output logic [AW-1:0]  wr_addr,
  output logic [2:0]     wr_size,
  output logic [DW-1:0]  wr_data,
  input  logic           wr_ready,
  output logic [NCH-1:0] irq
);

  logic [AW-1:0]  ch_src [NCH];
  logic [AW-1:0]  ch_dst [NCH];
  chan_cfg_t      ch_cfg [NCH];
  logic [NCH-1:0] ch_elig;
  logic           gnt_valid;
  logic [CHW-1:0] gnt_idx;
  logic           xfer_start, xfer_done, move_done;
  logic [CHW-1:0] cur_ch;
  logic [AW-1:0]  cur_src, cur_dst;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    dma_chan_regs #(.AW(AW), .CNT_W(CNT_W)) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_we && (cfg_ch == CHW'(i))),
      .wr_sel     (cfg_sel),
      .wr_data    (cfg_wdata),
      .hw_req     (hw_req[i]),
      .xfer_start (xfer_start && (gnt_idx == CHW'(i))),
      .wb_en      (xfer_done && (cur_ch == CHW'(i))),
      .wb_src     (cur_src),
      .wb_dst     (cur_dst),
      .src_addr   (ch_src[i]),
      .dst_addr   (ch_dst[i]),
      .cfg        (ch_cfg[i]),
      .eligible   (ch_elig[i]),
      .irq_pulse  (irq[i])
    );
  end

  dma_arbiter #(.NCH(NCH), .CHW(CHW)) arb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .elig      (ch_elig),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  dma_move_engine #(.NCH(NCH), .CHW(CHW), .AW(AW), .DW(DW)) eng_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .gnt_valid    (gnt_valid),
    .gnt_idx      (gnt_idx),
    .sel_src      (ch_src[gnt_idx]),
    .sel_dst      (ch_dst[gnt_idx]),
    .sel_cfg      (ch_cfg[gnt_idx]),
    .rd_valid     (rd_valid),
    .rd_addr      (rd_addr),
    .rd_size      (rd_size),
    .rd_ready     (rd_ready),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .wr_valid     (wr_valid),
    .wr_addr      (wr_addr),
    .wr_size      (wr_size),
    .wr_data      (wr_data),
    .wr_ready     (wr_ready),
    .xfer_start   (xfer_start),
    .xfer_done    (xfer_done),
    .move_done    (move_done),
    .cur_ch       (cur_ch),
    .cur_src      (cur_src),
    .cur_dst      (cur_dst)
  );

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));                                                       // R10
  AST_NO_GRANT_MIDXFER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wr_valid) |=> !xfer_start);                              // R8

endmodule

// File: tb/dma_hier_engine_tb_top.sv
`timescale 1ns/100ps
module dma_hier_engine_tb_top;

  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_we = 1'b0;
  logic [2:0]     cfg_ch = '0;
  logic [1:0]     cfg_sel = '0;
  logic [31:0]    cfg_wdata = '0;
  logic [NCH-1:0] hw_req = '0;
  logic           rd_valid, wr_valid;
  logic [31:0]    rd_addr, wr_addr;
  logic [2:0]     rd_size, wr_size;
  logic           rd_ready = 1'b0;
  logic           rd_rsp_valid = 1'b0;
  logic [255:0]   rd_rsp_data = '0;
  logic [255:0]   wr_data;
  logic           wr_ready = 1'b0;
  logic [NCH-1:0] irq;

  always #2.5 clk = ~clk;

  dma_hier_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .hw_req(hw_req), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_size(rd_size), .rd_ready(rd_ready), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_size(wr_size), .wr_data(wr_data), .wr_ready(wr_ready), .irq(irq)
  );

  // ---------------- reference model state ----------------
  longint unsigned m_src [NCH];
  longint unsigned m_dst [NCH];
  int  m_rem [NCH], m_mv [NCH], m_sz [NCH], m_sc [NCH], m_dc [NCH];
  bit  m_sh [NCH], m_dh [NCH], m_ie [NCH], m_pend [NCH];
  int  irq_exp [NCH], irq_seen [NCH];
  int  cur = -1, mleft = 0, writes_total = 0, rd_hs = 0, cyc = 0, seq = 0;
  int  order_log [$];
  logic [255:0] exp_data = '0, rsp_next = '0;
  bit  rsp_due = 0, prev_rd_stall = 0, prev_wr_stall = 0, done = 0;
  logic [31:0] prev_rd_addr = '0, prev_wr_addr = '0, last_rd = '0, last_wr = '0;
  int  n_checks = 0, n_errors = 0;

  task automatic check(input bit ok, input string msg);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic longint unsigned adv(longint unsigned a, int sz, bit hold, int circ);
    longint unsigned win, step;
    step = longint'(1) << sz;
    if (hold) return a;
    if (circ == 0) return (a + step) & 64'hFFFF_FFFF;
    win = longint'(1) << circ;
    return (a - (a % win)) + ((a % win + step) % win);
  endfunction

  function automatic logic [255:0] size_mask(int sz);
    if (sz >= 5) return '1;
    return (256'd1 << (8 << sz)) - 256'd1;
  endfunction

  // ---------------- memory responder and monitor ----------------
  initial begin
    for (int c = 0; c < NCH; c++) begin
      irq_exp[c] = 0; irq_seen[c] = 0; m_pend[c] = 0; m_rem[c] = 0;
    end
    forever begin
      @(negedge clk);
      cyc++;
      for (int c = 0; c < NCH; c++) if (irq[c] === 1'b1) irq_seen[c]++;
      if (prev_rd_stall)
        check(rd_valid === 1'b1 && rd_addr === prev_rd_addr,
              $sformatf("R12 read held: valid=%b addr=%h exp addr=%h", rd_valid, rd_addr, prev_rd_addr));
      if (prev_wr_stall)
        check(wr_valid === 1'b1 && wr_addr === prev_wr_addr,
              $sformatf("R12 write held: valid=%b addr=%h exp addr=%h", wr_valid, wr_addr, prev_wr_addr));
      rd_ready = rst_n && ((cyc % 3) != 1);
      wr_ready = rst_n && ((cyc % 4) != 2);
      if (rsp_due) begin
        rd_rsp_valid = 1'b1; rd_rsp_data = rsp_next; exp_data = rsp_next; rsp_due = 0;
      end else begin
        rd_rsp_valid = 1'b0;
      end
      if (rd_valid === 1'b1 && rd_ready) begin
        if (mleft == 0) begin
          cur = -1;
          for (int c = NCH - 1; c >= 0; c--)
            if (cur < 0 && m_pend[c] && m_rem[c] > 0) cur = c;
          check(cur >= 0, $sformatf("R7 transfer started with no eligible channel, addr=%h exp none", rd_addr));
          if (cur < 0) cur = 0;
          m_pend[cur] = 0; mleft = m_mv[cur]; order_log.push_back(cur);
        end
        check(rd_addr === 32'(m_src[cur]),
              $sformatf("R3 read addr ch%0d: %h exp %h", cur, rd_addr, 32'(m_src[cur])));
        check(rd_size === 3'(m_sz[cur]),
              $sformatf("R3 read size: %0d exp %0d", rd_size, m_sz[cur]));
        seq++;
        rsp_next = {8{rd_addr ^ (32'h5A00_0000 + 32'(seq) * 32'h0101_0101)}};
        rsp_due = 1; last_rd = rd_addr; rd_hs++;
      end
      if (wr_valid === 1'b1 && wr_ready) begin
        check(wr_addr === 32'(m_dst[cur]),
              $sformatf("R4 write addr ch%0d: %h exp %h", cur, wr_addr, 32'(m_dst[cur])));
        check((wr_data & size_mask(m_sz[cur])) === (exp_data & size_mask(m_sz[cur])),
              $sformatf("R2 write data: %h exp %h", wr_data[63:0], exp_data[63:0]));
        last_wr = wr_addr;
        m_src[cur] = adv(m_src[cur], m_sz[cur], m_sh[cur], m_sc[cur]);
        m_dst[cur] = adv(m_dst[cur], m_sz[cur], m_dh[cur], m_dc[cur]);
        mleft--; writes_total++;
        if (mleft == 0) begin
          m_rem[cur]--;
          if (m_rem[cur] == 0 && m_ie[cur]) irq_exp[cur]++;
        end
      end
      prev_rd_stall = (rd_valid === 1'b1) && !rd_ready; prev_rd_addr = rd_addr;
      prev_wr_stall = (wr_valid === 1'b1) && !wr_ready; prev_wr_addr = wr_addr;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic write_reg(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic program_ch(input int ch, input logic [31:0] s, input logic [31:0] d,
                            input int cnt, input int mv, input int sz, input bit sh,
                            input bit dh, input int sc, input int dc, input bit ie);
    logic [31:0] ctrl;
    ctrl = {14'd0, ie, 4'(dc), 4'(sc), dh, sh, 3'(sz), 4'(mv - 1)};
    write_reg(ch, 0, s);
    write_reg(ch, 1, d);
    write_reg(ch, 2, 32'(cnt));
    write_reg(ch, 3, ctrl);
    m_src[ch] = s; m_dst[ch] = d; m_rem[ch] = cnt; m_mv[ch] = mv; m_sz[ch] = sz;
    m_sh[ch] = sh; m_dh[ch] = dh; m_sc[ch] = sc; m_dc[ch] = dc; m_ie[ch] = ie;
  endtask

  task automatic pulse_req(input logic [NCH-1:0] mask);
    @(negedge clk);
    hw_req = mask;
    for (int c = 0; c < NCH; c++) if (mask[c] && m_rem[c] > 0) m_pend[c] = 1;
    @(negedge clk);
    hw_req = '0;
  endtask

  task automatic wait_quiet();
    bit busy;
    busy = 1;
    while (busy) begin
      @(negedge clk);
      busy = (mleft != 0) || rd_valid || wr_valid;
      for (int c = 0; c < NCH; c++) if (m_pend[c] && m_rem[c] > 0) busy = 1;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  // ---------------- main sequence ----------------
  initial begin
    int base, n;
    repeat (5) @(negedge clk);
    check(rd_valid === 1'b0 && wr_valid === 1'b0 && irq === '0,
          $sformatf("R11 reset outputs: rd=%b wr=%b irq=%b exp 0 0 0", rd_valid, wr_valid, irq));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // two-transfer transaction, incrementing pointers, interrupt enabled
    program_ch(1, 32'h1000, 32'h2000, 2, 4, 2, 0, 0, 0, 0, 1);
    pulse_req(8'h02); wait_quiet();
    check(irq_seen[1] == 0, $sformatf("R10 no irq mid-transaction: %0d exp 0", irq_seen[1]));
    pulse_req(8'h02); wait_quiet();
    check(writes_total == 8, $sformatf("R1 moves in two transfers: %0d exp 8", writes_total));
    check(irq_seen[1] == 1, $sformatf("R10 irq at end: %0d exp 1", irq_seen[1]));
    check(last_rd == 32'h101C, $sformatf("R3 final read addr: %h exp 101c", last_rd));

    // held pointers, 32-byte moves
    program_ch(3, 32'h4000, 32'h5000, 2, 3, 5, 1, 1, 0, 0, 1);
    pulse_req(8'h08); wait_quiet();
    pulse_req(8'h08); wait_quiet();
    check(last_rd == 32'h4000 && last_wr == 32'h5000,
          $sformatf("R4 held pointers: rd %h wr %h exp 4000 5000", last_rd, last_wr));

    // circular source window of 16 bytes, no interrupt
    program_ch(2, 32'h3008, 32'h6000, 1, 6, 3, 0, 0, 4, 0, 0);
    pulse_req(8'h04); wait_quiet();
    check(last_rd == 32'h3000 && last_wr == 32'h6028,
          $sformatf("R5 circular source: rd %h wr %h exp 3000 6028", last_rd, last_wr));
    check(irq_seen[2] == 0, $sformatf("R10 disabled irq: %0d exp 0", irq_seen[2]));

    // simultaneous requests
    program_ch(0, 32'hB000, 32'hC000, 1, 2, 0, 0, 0, 0, 0, 1);
    program_ch(4, 32'hB100, 32'hC100, 1, 2, 0, 0, 0, 0, 0, 1);
    program_ch(6, 32'hB200, 32'hC200, 1, 2, 0, 0, 0, 0, 0, 1);
    base = order_log.size();
    pulse_req(8'h51); wait_quiet();
    n = order_log.size();
    check(n == base + 3 && order_log[base] == 6 && order_log[base+1] == 4 && order_log[base+2] == 0,
          $sformatf("R7 grant order: %0d,%0d,%0d exp 6,4,0", order_log[base], order_log[base+1], order_log[base+2]));

    // pre-emption between transfers and request latched mid-transfer
    program_ch(5, 32'h7000, 32'h8000, 3, 8, 1, 0, 0, 0, 0, 1);
    program_ch(7, 32'h9000, 32'hA000, 1, 2, 2, 0, 0, 0, 0, 1);
    base = order_log.size();
    pulse_req(8'h20);
    while (order_log.size() == base) @(negedge clk);
    pulse_req(8'hA0);
    wait_quiet();
    pulse_req(8'h20);
    wait_quiet();
    n = order_log.size();
    check(n == base + 4 && order_log[base+1] == 7 && order_log[base+2] == 5,
          $sformatf("R8 overtaken then resumed: second %0d third %0d exp 7 5", order_log[base+1], order_log[base+2]));
    check(order_log[base+3] == 5 && irq_seen[5] == 1,
          $sformatf("R9 latched mid-transfer request: last %0d irq %0d exp 5 1", order_log[base+3], irq_seen[5]));
    check(last_rd == 32'h702E, $sformatf("R8 resumed pointer: %h exp 702e", last_rd));

    // request to an exhausted channel
    n = rd_hs;
    pulse_req(8'h01);
    repeat (30) @(negedge clk);
    check(rd_hs == n && rd_valid === 1'b0,
          $sformatf("R6 exhausted channel request: reads %0d exp %0d", rd_hs, n));

    for (int c = 0; c < NCH; c++)
      check(irq_seen[c] == irq_exp[c],
            $sformatf("R10 irq count ch%0d: %0d exp %0d", c, irq_seen[c], irq_exp[c]));

    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired: cycles 150000 exp completion");
      finish_run();
    end
  end

endmodule